// File: doc/BRIEF.md
# Selectable-Tap Binary Timer

This block is a clocked timer built from a sixteen-stage binary ripple chain, rewritten as one synchronous counter. A two-bit select picks which stage drives the timer output. The select map is deliberately non-monotonic, and one of its codes feeds the upper half of the chain straight from the input clock. In recycle mode the chosen stage produces a square wave at the input clock divided by 2^n. In single-cycle mode the output changes level once, a fixed number of clocks after the block is cleared, and then stays at that level until the block is re-armed.

A polarity input sets the output level while the block is cleared. A clear comes from any of three sources: the master reset, a power-on pulse when automatic reset is enabled, or a change of level on the mode input. A clear zeroes every counter stage and the single-cycle latch on the same clock edge.

Timing convention: the clear edge is the rising edge at which a clear source is sampled active. Edge k is the k-th rising edge after the clear edge with no clear active. The half count h is 2^(n-1), where n is the length of the selected stage chain.

Top module: `tap_timer`

## Requirements
- R1: The select input `sel` sets n as follows: 2'b00 gives n=13 (h=4096), 2'b01 gives n=10 (h=512), 2'b11 gives n=16 (h=32768).
- R2: With `sel`=2'b10, stages 9 to 16 advance on every input clock instead of on the carry out of stage 8. The top stage then acts as n=8 (h=128, divide by 256).
- R3: When `mrst` is high at a rising edge, the whole count and the single-cycle latch are cleared on that edge, whatever the count was. Counting restarts from zero.
- R4: After any clear edge, `tmr_out` equals `pol`, sampled at that edge.
- R5: With `recycle`=1, at edge k `tmr_out` equals `pol` XOR bit (n-1) of k. The output therefore first changes at edge h and toggles every h edges after that.
- R6: With `recycle`=0, `tmr_out` equals `pol` for edges 1 to h-1. From edge h onward it equals the inverse of `pol`, and it holds that level until the next clear.
- R7: A rising edge at which `recycle` differs from its value at the previous edge is a clear edge. This re-arms single-cycle operation without `mrst`.
- R8: `por` high at an edge acts as a clear only while `auto_rst_n` is 0. While `auto_rst_n` is 1, `por` has no effect on `tmr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| por | input | 1 | Power-on reset pulse, synchronous |
| auto_rst_n | input | 1 | 0 lets `por` clear the timer |
| sel | input | 2 | Stage select (see R1, R2) |
| recycle | input | 1 | 1 = free-running divider, 0 = single change |
| pol | input | 1 | Output level while cleared |
| tmr_out | output | 1 | Registered timer output |

## Verification
The hardest state to reach is the latched single-cycle state at the longest tap. The output must hold after 32768 counting clocks, and that hold can only be seen by running past the transition edge. The stimulus runs each select code from a master reset to a few edges beyond its half count in both modes. A scoreboard predicts the output at every edge from k, so an off-by-one edge or a missed bypass appears as a mismatch in a specific cycle. The latched state is then reused to show that a gated power-on pulse is ignored and that a mode flip alone re-arms the block.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  localparam int CHAIN_LEN = 16;
  localparam int FEED_STAGE = 9;

  typedef enum logic [1:0] {
    TAP_S13 = 2'b00,
    TAP_S10 = 2'b01,
    TAP_S8  = 2'b10,
    TAP_S16 = 2'b11
  } tap_sel_e;

  // Number of stages whose output forms the selected divide ratio.
  function automatic int tap_len(tap_sel_e s);
    case (s)
      TAP_S13: return 13;
      TAP_S10: return 10;
      TAP_S8:  return 8;
      default: return 16;
    endcase
  endfunction

  // Physical counter bit that carries the selected stage. The 8-stage
  // code reads the top stage, whose upper segment is fed directly.
  function automatic int tap_bit(tap_sel_e s);
    if (s == TAP_S8) return CHAIN_LEN - 1;
    return tap_len(s) - 1;
  endfunction
endpackage

// File: rtl/tap_timer_clr.sv
module tap_timer_clr (
  input  logic clk,
  input  logic mrst,
  input  logic por,
  input  logic auto_rst_n,
  input  logic mode,
  output logic clr
);
  logic mode_q;
  logic mode_chg;
  logic por_clr;

  always_ff @(posedge clk) mode_q <= mode;

  assign mode_chg = mode ^ mode_q;
  assign por_clr  = por & ~auto_rst_n;
  assign clr      = mrst | por_clr | mode_chg;
endmodule

// File: rtl/tap_timer_chain.sv
module tap_timer_chain
  import tap_timer_pkg::*;
#(
  parameter int STAGES = CHAIN_LEN,
  parameter int FEED   = FEED_STAGE
) (
  input  logic     clk,
  input  logic     hard_rst,
  input  logic     clr,
  input  logic     bypass,
  input  tap_sel_e tap_sel,
  output logic     tap_nxt
);
  localparam int UPW = STAGES - FEED + 1;

  logic [STAGES-1:0] cnt_q, cnt_d, ena;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign ena[g] = 1'b1;
    end else if (g == FEED - 1) begin : g_feed
      assign ena[g] = bypass | (ena[g-1] & cnt_q[g-1]);
    end else begin : g_ripple
      assign ena[g] = ena[g-1] & cnt_q[g-1];
    end
    assign cnt_d[g] = clr ? 1'b0 : (cnt_q[g] ^ ena[g]);
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign tap_nxt = cnt_d[tap_bit(tap_sel)];

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (hard_rst)
    clr |=> cnt_q == '0); // R3
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (hard_rst)
    (!clr && !bypass) |=> cnt_q == STAGES'($past(cnt_q) + 1'b1)); // R5
  AST_FEED_STEP: assert property (@(posedge clk) disable iff (hard_rst)
    (!clr && bypass) |=> cnt_q[STAGES-1:FEED-1] ==
      UPW'($past(cnt_q[STAGES-1:FEED-1]) + 1'b1)); // R2
endmodule

// File: rtl/tap_timer_out.sv
module tap_timer_out (
  input  logic clk,
  input  logic hard_rst,
  input  logic clr,
  input  logic recycle,
  input  logic pol,
  input  logic tap_nxt,
  output logic out_q
);
  logic latch_q, latch_d, out_d;

  assign latch_d = clr ? 1'b0 : (latch_q | tap_nxt);
  assign out_d   = clr ? pol : (pol ^ (recycle ? tap_nxt : latch_d));

  always_ff @(posedge clk) begin
    latch_q <= latch_d;
    out_q   <= out_d;
  end

  AST_CLR_LEVEL: assert property (@(posedge clk) disable iff (hard_rst)
    clr |=> out_q == $past(pol)); // R4
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (hard_rst)
    (!clr && !recycle && latch_q) |=> out_q == !$past(pol)); // R6
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       mrst,
  input  logic       por,
  input  logic       auto_rst_n,
  input  logic [1:0] sel,
  input  logic       recycle,
  input  logic       pol,
  output logic       tmr_out
);
  logic     clr;
  logic     tap_nxt;
  logic     bypass;
  tap_sel_e tap_sel;

  assign tap_sel = tap_sel_e'(sel);
  assign bypass  = (tap_sel == TAP_S8);

  tap_timer_clr u_clr (
    .clk(clk), .mrst(mrst), .por(por), .auto_rst_n(auto_rst_n),
    .mode(recycle), .clr(clr)
  );

  tap_timer_chain #(.STAGES(CHAIN_LEN), .FEED(FEED_STAGE)) u_chain (
    .clk(clk), .hard_rst(mrst), .clr(clr), .bypass(bypass),
    .tap_sel(tap_sel), .tap_nxt(tap_nxt)
  );

  tap_timer_out u_out (
    .clk(clk), .hard_rst(mrst), .clr(clr), .recycle(recycle),
    .pol(pol), .tap_nxt(tap_nxt), .out_q(tmr_out)
  );
endmodule

// File: tb/test_tap_timer.sv
module test_tap_timer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mrst, por, auto_rst_n, recycle, pol, tmr_out;
  logic [1:0] sel;

  typedef struct {
    string req;
    logic  exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  tap_timer i_tap_timer (
    .clk(clk), .mrst(mrst), .por(por), .auto_rst_n(auto_rst_n),
    .sel(sel), .recycle(recycle), .pol(pol), .tmr_out(tmr_out)
  );

  // Monitor: compares expected items shortly after each falling edge.
  always @(negedge clk) begin
    item_t it;
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (tmr_out !== it.exp) begin
        errors++;
        $display("FAIL %s: tmr_out=%0b expected %0b", it.req, tmr_out, it.exp);
      end
    end
  end

  function automatic int half_of(logic [1:0] s);
    case (s)
      2'b00: return 4096;
      2'b01: return 512;
      2'b10: return 128;
      default: return 32768;
    endcase
  endfunction

  function automatic logic predict(int k, int h, bit rec, bit p);
    if (rec) return p ^ logic'((k / h) % 2);
    return p ^ (k >= h);
  endfunction

  task automatic expect_now(string r, logic e);
    q.push_back('{r, e});
  endtask

  // Clear with mrst; the next sample must show the polarity level (R4).
  task automatic hard_start(logic [1:0] s, bit rec, bit p);
    @(negedge clk);
    sel = s; recycle = rec; pol = p; mrst = 1'b1;
    @(negedge clk);
    mrst = 1'b0;
    expect_now("R4", p);
  endtask

  task automatic run(string r, logic [1:0] s, bit rec, bit p, int from, int upto);
    for (int k = from; k <= upto; k++) begin
      @(negedge clk);
      expect_now(r, predict(k, half_of(s), rec, p));
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 195000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    mrst = 1'b1; por = 1'b0; auto_rst_n = 1'b1;
    sel = 2'b00; recycle = 1'b0; pol = 1'b0;
    repeat (3) @(negedge clk);

    // Single-cycle mode, every select code (R1, R2, R6)
    for (int s = 0; s < 4; s++) begin
      hard_start(2'(s), 1'b0, s[0]);
      run((s == 2) ? "R2/R6" : "R1/R6", 2'(s), 1'b0, s[0], 1,
          half_of(2'(s)) + 16);
    end

    // Recycle mode (R1, R2, R5)
    hard_start(2'b00, 1'b1, 1'b1);
    run("R1/R5", 2'b00, 1'b1, 1'b1, 1, 4 * 4096);
    hard_start(2'b01, 1'b1, 1'b0);
    run("R1/R5", 2'b01, 1'b1, 1'b0, 1, 4 * 512);
    hard_start(2'b10, 1'b1, 1'b1);
    run("R2/R5", 2'b10, 1'b1, 1'b1, 1, 4 * 128);
    hard_start(2'b11, 1'b1, 1'b0);
    run("R1/R5", 2'b11, 1'b1, 1'b0, 1, 32768 + 8);

    // Master reset in the middle of a count (R3)
    hard_start(2'b01, 1'b1, 1'b0);
    run("R5", 2'b01, 1'b1, 1'b0, 1, 700);
    hard_start(2'b01, 1'b1, 1'b0);
    run("R3", 2'b01, 1'b1, 1'b0, 1, 520);

    // Mode flip re-arms without mrst (R7)
    hard_start(2'b10, 1'b0, 1'b1);
    run("R6", 2'b10, 1'b0, 1'b1, 1, 200);
    @(negedge clk); recycle = 1'b1;
    @(negedge clk); expect_now("R7", 1'b1);
    run("R7", 2'b10, 1'b1, 1'b1, 1, 300);
    @(negedge clk); recycle = 1'b0;
    @(negedge clk); expect_now("R7", 1'b1);
    run("R7", 2'b10, 1'b0, 1'b1, 1, 200);

    // Power-on pulse gated by auto_rst_n (R8)
    hard_start(2'b10, 1'b0, 1'b0);
    run("R6", 2'b10, 1'b0, 1'b0, 1, 150);
    @(negedge clk); auto_rst_n = 1'b1; por = 1'b1;
    @(negedge clk); por = 1'b0; expect_now("R8", 1'b1);
    run("R8", 2'b10, 1'b0, 1'b0, 151, 160);
    @(negedge clk); auto_rst_n = 1'b0; por = 1'b1;
    @(negedge clk); por = 1'b0; expect_now("R8", 1'b0);
    run("R8", 2'b10, 1'b0, 1'b0, 1, 140);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule